// File: doc/BRIEF.md
# Banked Register-File Address Generator

This block turns the 7-bit register field of an instruction into a 9-bit data-memory address for a small banked 8-bit controller. The register space is split into four banks of 128 locations each. A direct access takes its bank from two bank-select bits of a local status register. An access to offset 00h is indirect: the block substitutes an 8-bit pointer register and takes the ninth address bit from a separate status bit. The status register and the pointer register live inside the block, and they answer at the same offset in every bank. Every other location is passed on to an external RAM array through a write strobe and a read strobe.

Writes to the status register are filtered. The two power-state bits hold their reset value and cannot be changed by a write. The three arithmetic flags take the ALU value whenever the same instruction also reports a flag update. A bank change takes effect on the access after the one that writes it. An indirect access whose resolved offset is 00h reads as zero and writes nothing.

Top module: `bank_addr_gen`

## Requirements
- R1: A direct access (op_addr not 00h) resolves to mem_addr = {status[6:5], op_addr}, so bank-select code n places the access at n×80h plus the offset.
- R2: An access with op_addr = 00h resolves to mem_addr = {status[7], ptr[7:0]}, where ptr is the pointer register.
- R3: An indirect access whose resolved offset (mem_addr[6:0]) is 00h returns rd_data = 00h and raises neither mem_re nor mem_we.
- R4: An indirect write whose resolved offset is 00h changes neither the status register nor the pointer register.
- R5: The status register answers at offset 03h and the pointer register at offset 04h in every bank, whether reached directly or through the pointer. Reads return their value, writes update them, and neither raises mem_we or mem_re.
- R6: A status write with flag_we low loads bits 7:5 and 2:0 from wr_data on the next clock edge.
- R7: When flag_we is high, bits 2:0 of status take {flag_z, flag_dc, flag_c} on the next edge, even if the same access also writes the status register. Bits 7:5 still follow wr_data in that case.
- R8: Status bits 4:3 read as 1 after reset, and no write changes them.
- R9: After reset, status reads 18h and the pointer register reads 00h.
- R10: A status write changes the bank or indirect bit only for later accesses. The writing access itself resolves with the old value.
- R11: For any location that is not a local register, rd_data equals ram_rdata. mem_we equals wr_en and mem_re equals rd_en.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_addr | input | 7 | Register field of the current instruction |
| rd_en | input | 1 | Read of the addressed location |
| wr_en | input | 1 | Write of the addressed location |
| wr_data | input | 8 | Write data |
| flag_we | input | 1 | ALU updates the arithmetic flags this cycle |
| flag_z | input | 1 | Zero flag from the ALU |
| flag_dc | input | 1 | Digit-carry flag from the ALU |
| flag_c | input | 1 | Carry flag from the ALU |
| ram_rdata | input | 8 | Read data from the external RAM array |
| mem_addr | output | 9 | Resolved data-memory address |
| mem_we | output | 1 | Write strobe to the RAM array |
| mem_re | output | 1 | Read strobe to the RAM array |
| rd_data | output | 8 | Read data after the local-register mux |
| status_q | output | 8 | Current status register |

## Verification
The main collision is an instruction that writes the status register while the ALU also reports new flags. In that cycle the bits come from two sources, and the split must be exact. The bench drives a status write together with flag_we, using data whose low bits differ from the flag values. It then reads the status register back and expects the flag values in bits 2:0 and the written value in bits 7:5. A second overlap is a status write whose own address depends on the bank bits it is changing. The bench checks that this access resolves in the old bank and that the next access resolves in the new one.

// File: rtl/bank_pkg.sv
package bank_pkg;
    localparam int DATA_W = 8;
    localparam int BANK_W = 2;
    localparam int OFS_W  = DATA_W - BANK_W + 1;
    localparam int ADDR_W = BANK_W + OFS_W;

    // status bit positions; the bank bits and the indirect bit feed the address mux
    localparam int ST_IRP = 7;
    localparam int ST_RPH = 6;
    localparam int ST_RPL = 5;
    localparam int ST_TO  = 4;
    localparam int ST_PD  = 3;

    typedef enum logic [1:0] {
        TGT_RAM    = 2'd0,
        TGT_NULL   = 2'd1,
        TGT_STATUS = 2'd2,
        TGT_PTR    = 2'd3
    } tgt_e;

    typedef struct packed {
        logic [DATA_W-1:0] status;
        logic [DATA_W-1:0] ptr;
    } core_regs_t;
endpackage

// File: rtl/bank_addr_mux.sv
module bank_addr_mux
    import bank_pkg::*;
#(
    parameter int STATUS_OFS = 3,
    parameter int PTR_OFS    = 4
) (
    input  logic [OFS_W-1:0]  op_addr,
    input  logic [DATA_W-1:0] status_q,
    input  logic [DATA_W-1:0] ptr_q,
    output logic [ADDR_W-1:0] eff_addr,
    output tgt_e              tgt
);
    localparam logic [OFS_W-1:0] NULL_OFS = '0;
    localparam logic [OFS_W-1:0] ST_OFS   = OFS_W'(STATUS_OFS);
    localparam logic [OFS_W-1:0] PT_OFS   = OFS_W'(PTR_OFS);

    logic             indirect;
    logic [OFS_W-1:0] offset;

    always_comb begin
        indirect = (op_addr == NULL_OFS);
        if (indirect) begin
            eff_addr = {status_q[ST_IRP], ptr_q};
        end else begin
            eff_addr = {status_q[ST_RPH:ST_RPL], op_addr};
        end
        offset = eff_addr[OFS_W-1:0];
        // the local registers decode on the offset only, so they appear in every bank
        if (offset == NULL_OFS) begin
            tgt = TGT_NULL;
        end else if (offset == ST_OFS) begin
            tgt = TGT_STATUS;
        end else if (offset == PT_OFS) begin
            tgt = TGT_PTR;
        end else begin
            tgt = TGT_RAM;
        end
    end
endmodule

// File: rtl/bank_core_regs.sv
module bank_core_regs
    import bank_pkg::*;
#(
    parameter logic [DATA_W-1:0] STATUS_RST = 8'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  tgt_e              tgt,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              flag_we,
    input  logic [2:0]        flags,
    output logic [DATA_W-1:0] status_q,
    output logic [DATA_W-1:0] ptr_q
);
    core_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en && tgt == TGT_STATUS) begin
            regs_d.status[ST_IRP:ST_RPL] = wr_data[ST_IRP:ST_RPL];
            if (!flag_we) begin
                regs_d.status[2:0] = wr_data[2:0];
            end
        end
        if (flag_we) begin
            regs_d.status[2:0] = flags;
        end
        if (wr_en && tgt == TGT_PTR) begin
            regs_d.ptr = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{status: STATUS_RST, ptr: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign status_q = regs_q.status;
    assign ptr_q    = regs_q.ptr;

    assert_power_bits_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(status_q[ST_TO:ST_PD]));

    assert_flags_win_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |=> status_q[2:0] == $past(flags));

    assert_status_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tgt == TGT_STATUS && !flag_we) |=>
            (status_q[7:5] == $past(wr_data[7:5]) && status_q[2:0] == $past(wr_data[2:0])));

    assert_ptr_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tgt == TGT_PTR) |=> ptr_q == $past(wr_data));
endmodule

// File: rtl/bank_addr_gen.sv
module bank_addr_gen
    import bank_pkg::*;
#(
    parameter int STATUS_OFS = 3,
    parameter int PTR_OFS    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFS_W-1:0]  op_addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              flag_we,
    input  logic              flag_z,
    input  logic              flag_dc,
    input  logic              flag_c,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] status_q
);
    tgt_e              tgt;
    logic [DATA_W-1:0] ptr_q;

    bank_addr_mux #(.STATUS_OFS(STATUS_OFS), .PTR_OFS(PTR_OFS)) u_mux (
        .op_addr  (op_addr),
        .status_q (status_q),
        .ptr_q    (ptr_q),
        .eff_addr (mem_addr),
        .tgt      (tgt)
    );

    bank_core_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .tgt      (tgt),
        .wr_data  (wr_data),
        .flag_we  (flag_we),
        .flags    ({flag_z, flag_dc, flag_c}),
        .status_q (status_q),
        .ptr_q    (ptr_q)
    );

    always_comb begin
        mem_we = wr_en && (tgt == TGT_RAM);
        mem_re = rd_en && (tgt == TGT_RAM);
        case (tgt)
            TGT_STATUS: rd_data = status_q;
            TGT_PTR:    rd_data = ptr_q;
            TGT_NULL:   rd_data = '0;
            default:    rd_data = ram_rdata;
        endcase
    end

    assert_null_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && op_addr == '0 && ptr_q[OFS_W-1:0] == '0) |=>
            ($stable(ptr_q) && $stable(status_q)));

    assert_null_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_addr == '0 && ptr_q[OFS_W-1:0] == '0) |-> (rd_data == '0 && !mem_we && !mem_re));

    assert_bank_next_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_addr != '0) |-> mem_addr[ADDR_W-1:OFS_W] == status_q[ST_RPH:ST_RPL]);
endmodule

// File: tb/bank_addr_gen_bench.sv
module bank_addr_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] op_addr = '0;
    logic       rd_en = 1'b0, wr_en = 1'b0, flag_we = 1'b0;
    logic       flag_z = 1'b0, flag_dc = 1'b0, flag_c = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] ram_rdata;
    logic [8:0] mem_addr;
    logic       mem_we, mem_re;
    logic [7:0] rd_data, status_q;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    // the RAM model returns a value that depends on the address it sees
    assign ram_rdata = mem_addr[7:0] ^ 8'h5A;

    bank_addr_gen u_bank_addr_gen (
        .clk(clk), .rst_n(rst_n), .op_addr(op_addr), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .flag_we(flag_we), .flag_z(flag_z), .flag_dc(flag_dc),
        .flag_c(flag_c), .ram_rdata(ram_rdata), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_re(mem_re), .rd_data(rd_data), .status_q(status_q)
    );

    typedef struct {
        logic [8:0] addr;
        logic       we;
        logic       re;
        logic [7:0] rd;
        logic [7:0] st;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    event sample_ev;
    logic [7:0] m_st = 8'h18;
    logic [7:0] m_ptr = 8'h00;

    task automatic check(input string tag, input string what, input logic [8:0] act, input logic [8:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // driver: applies one access and pushes the expected outcome from the reference model
    task automatic access(input logic [6:0] op, input logic rd, input logic wr, input logic [7:0] d,
                          input logic fw, input logic [2:0] fl, input string tag);
        exp_t e;
        logic [8:0] ea;
        int kind;
        @(negedge clk);
        op_addr = op; rd_en = rd; wr_en = wr; wr_data = d; flag_we = fw;
        {flag_z, flag_dc, flag_c} = fl;
        ea = (op == 7'd0) ? {m_st[7], m_ptr} : {m_st[6:5], op};
        kind = (ea[6:0] == 7'd0) ? 1 : (ea[6:0] == 7'd3) ? 2 : (ea[6:0] == 7'd4) ? 3 : 0;
        e.addr = ea;
        e.we = wr && kind == 0;
        e.re = rd && kind == 0;
        e.rd = (kind == 1) ? 8'h00 : (kind == 2) ? m_st : (kind == 3) ? m_ptr : (ea[7:0] ^ 8'h5A);
        e.st = m_st;
        e.tag = tag;
        exp_q.push_back(e);
        -> sample_ev;
        if (wr && kind == 2) begin
            m_st[7:5] = d[7:5];
            if (!fw) m_st[2:0] = d[2:0];
        end
        if (fw) m_st[2:0] = fl;
        if (wr && kind == 3) m_ptr = d;
        @(posedge clk);
    endtask

    // monitor: compares outputs a little after the inputs settle, well before the next edge
    initial begin
        forever begin
            @(sample_ev);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, "mem_addr", mem_addr, e.addr);
                check(e.tag, "mem_we", {8'd0, mem_we}, {8'd0, e.we});
                check(e.tag, "mem_re", {8'd0, mem_re}, {8'd0, e.re});
                check(e.tag, "rd_data", {1'b0, rd_data}, {1'b0, e.rd});
                check(e.tag, "status_q", {1'b0, status_q}, {1'b0, e.st});
            end
        end
    end

    initial begin
        #4000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R9 R8: reset values of the status and pointer registers
        access(7'h03, 1, 0, 8'h00, 0, 3'b000, "R9 status reset");
        access(7'h04, 1, 0, 8'h00, 0, 3'b000, "R9 ptr reset");
        // R1 R11: direct access in bank 0 reaches RAM
        access(7'h25, 1, 0, 8'h00, 0, 3'b000, "R1 R11 direct bank0 read");
        access(7'h7F, 0, 1, 8'h33, 0, 3'b000, "R11 direct bank0 write");
        // R8: clearing the status word leaves bits 4:3 at 1
        access(7'h03, 0, 1, 8'h00, 0, 3'b000, "R8 write zero");
        access(7'h03, 1, 0, 8'h00, 0, 3'b000, "R8 readback");
        // R10: the bank write resolves in the old bank, the next access in the new one
        access(7'h03, 0, 1, 8'h40, 0, 3'b000, "R10 select bank2");
        access(7'h25, 1, 0, 8'h00, 0, 3'b000, "R1 R10 bank2 read");
        access(7'h03, 0, 1, 8'h60, 0, 3'b000, "R10 write from bank2");
        access(7'h10, 0, 1, 8'h11, 0, 3'b000, "R1 bank3 write");
        // R5: local registers mirrored in bank 3
        access(7'h04, 0, 1, 8'h3C, 0, 3'b000, "R5 ptr write bank3");
        access(7'h04, 1, 0, 8'h00, 0, 3'b000, "R5 ptr read bank3");
        access(7'h03, 1, 0, 8'h00, 0, 3'b000, "R5 status read bank3");
        // R2: indirect through the pointer, both values of the indirect bit
        access(7'h00, 1, 0, 8'h00, 0, 3'b000, "R2 indirect low half");
        access(7'h03, 0, 1, 8'h80, 0, 3'b000, "R2 set indirect bit");
        access(7'h00, 0, 1, 8'h99, 0, 3'b000, "R2 indirect high half write");
        access(7'h00, 1, 0, 8'h00, 0, 3'b000, "R2 indirect high half read");
        // R3 R4: null pointer at offset 0, pointer 00h then 80h
        access(7'h04, 0, 1, 8'h00, 0, 3'b000, "R3 ptr to zero");
        access(7'h00, 1, 0, 8'h00, 0, 3'b000, "R3 null read");
        access(7'h00, 0, 1, 8'h77, 0, 3'b000, "R4 null write");
        access(7'h04, 1, 0, 8'h00, 0, 3'b000, "R4 ptr unchanged");
        access(7'h03, 1, 0, 8'h00, 0, 3'b000, "R4 status unchanged");
        access(7'h04, 0, 1, 8'h80, 0, 3'b000, "R3 ptr to 80h");
        access(7'h00, 0, 1, 8'hFF, 0, 3'b000, "R4 null write 80h");
        access(7'h00, 1, 0, 8'h00, 0, 3'b000, "R3 null read 80h");
        access(7'h04, 1, 0, 8'h00, 0, 3'b000, "R4 ptr still 80h");
        // R5: status reached through the pointer
        access(7'h04, 0, 1, 8'h03, 0, 3'b000, "R5 ptr to status");
        access(7'h00, 0, 1, 8'h20, 0, 3'b000, "R5 indirect status write");
        access(7'h03, 1, 0, 8'h00, 0, 3'b000, "R5 indirect status readback");
        // R6: plain status write loads the low flags
        access(7'h03, 0, 1, 8'h05, 0, 3'b000, "R6 status write flags");
        access(7'h03, 1, 0, 8'h00, 0, 3'b000, "R6 readback");
        // R7: ALU flags win over the same-cycle status write
        access(7'h03, 0, 1, 8'h47, 1, 3'b010, "R7 write with flag update");
        access(7'h03, 1, 0, 8'h00, 0, 3'b000, "R7 readback");
        access(7'h55, 1, 0, 8'h00, 1, 3'b101, "R7 flag update alone");
        access(7'h03, 1, 0, 8'h00, 0, 3'b000, "R7 readback flags");
        access(7'h55, 1, 1, 8'h12, 0, 3'b000, "R11 bank2 read and write");
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; flag_we = 1'b0;
        #5;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule